// File: doc/BRIEF.md
# Character Bank and Nametable Mapper

This block sits on the video side of a cartridge memory controller. A command port, decoded elsewhere, hands it parameter writes as a 4-bit command code plus an 8-bit value. Codes 0 to 7 each load the bank number for one of eight 1 KiB pattern windows. Code 12 loads a 2-bit mirroring mode. Every other code belongs to other blocks, and this block ignores it.

The 14-bit video address is translated combinationally. Bits 12:10 pick a window. That window's 8-bit bank number is placed above the 10-bit offset to form an 18-bit address into a 256 KiB character memory. For addresses in the $2000-$2FFF range, the block raises a nametable-region flag. It also drives the select line that chooses which of the two on-board nametable RAM halves is used. The mirroring mode decides how that select line is derived.

Top module: `chr_nt_mapper`

## Requirements
- R1: While `rst` is high at a clock edge, all eight bank numbers and the mirroring mode clear to 0. After reset, every pattern address maps to bank 0, and the mode is vertical.
- R2: A write (`cmd_we` high at a rising edge) with code N in 0..7 stores the full 8-bit `cmd_data` as the bank number of window N. Window N covers video addresses N*$400 to N*$400+$3FF.
- R3: `chr_addr` equals {bank of window `vaddr[12:10]`, `vaddr[9:0]`}. It follows `vaddr` in the same cycle, with no register on the path.
- R4: Writes with codes 8 to 11 and 13 to 15 change no bank number and do not change the mirroring mode.
- R5: A write with code 12 loads `cmd_data[1:0]` as the mirroring mode and ignores `cmd_data[7:2]`. The encodings are 0 = vertical, 1 = horizontal, 2 = single-screen low, 3 = single-screen high.
- R6: In vertical mode (0), `ntab_sel` equals `vaddr[10]`.
- R7: In horizontal mode (1), `ntab_sel` equals `vaddr[11]`.
- R8: In mode 2, `ntab_sel` is held at 0. In mode 3, `ntab_sel` is held at 1, whatever the address.
- R9: `nt_hit` is high exactly when `vaddr[13:12]` is 2'b10, that is, for addresses $2000 to $2FFF.
- R10: When `cmd_we` is low, the code and data inputs have no effect on any stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Parameter write strobe |
| cmd_sel | input | 4 | Command code of the write |
| cmd_data | input | 8 | Parameter value of the write |
| vaddr | input | 14 | Video bus address |
| chr_addr | output | 18 | Banked character memory address |
| nt_hit | output | 1 | High when vaddr is in the nametable range |
| ntab_sel | output | 1 | Nametable RAM half select |

## Verification
The bench builds the block with its default parameters: 8-bit banks, 1 KiB windows and eight windows. This makes the full 256 KiB address space reachable. The bank values are chosen so that the all-ones, all-zero, lone-MSB and lone-LSB bank patterns each land in a different window. The window edges $x000/$x3FF are probed, so a wrong window slice or a truncated bank bit shows up directly on `chr_addr`. All four mirroring modes are walked with addresses that toggle bit 10 and bit 11 independently. A mid-run reset confirms that the programmed state is cleared.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;

    localparam int CMD_W = 4;
    localparam logic [CMD_W-1:0] CMD_MIRROR = 4'hC;

    typedef enum logic [1:0] {
        MIR_VERT  = 2'd0,
        MIR_HORZ  = 2'd1,
        MIR_ONE_L = 2'd2,
        MIR_ONE_H = 2'd3
    } mir_mode_e;

    function automatic logic nt_pick(mir_mode_e mode, logic a10, logic a11);
        case (mode)
            MIR_VERT:  return a10;
            MIR_HORZ:  return a11;
            MIR_ONE_L: return 1'b0;
            default:   return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/chr_bank_file.sv
module chr_bank_file
    import chr_map_pkg::*;
#(
    parameter int BANK_W   = 8,
    parameter int WIN_CNT  = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [CMD_W-1:0]            sel,
    input  logic [BANK_W-1:0]           data,
    output logic [WIN_CNT*BANK_W-1:0]   bank_flat
);

    for (genvar g = 0; g < WIN_CNT; g++) begin : g_win
        logic [BANK_W-1:0] bank_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                bank_q <= '0;
            end else if (we && (sel == CMD_W'(g))) begin
                bank_q <= data;
            end
        end
        assign bank_flat[g*BANK_W +: BANK_W] = bank_q;
    end

endmodule

// File: rtl/nt_mirror_ctrl.sv
module nt_mirror_ctrl
    import chr_map_pkg::*;
#(
    parameter int VA_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CMD_W-1:0]  sel,
    input  logic [1:0]        mode_data,
    input  logic [VA_W-1:0]   vaddr,
    output mir_mode_e         mode_q,
    output logic              nt_hit,
    output logic              ntab_sel
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MIR_VERT;
        end else if (we && (sel == CMD_MIRROR)) begin
            mode_q <= mir_mode_e'(mode_data);
        end
    end

    always_comb begin
        nt_hit   = (vaddr[VA_W-1 -: 2] == 2'b10);
        ntab_sel = nt_pick(mode_q, vaddr[10], vaddr[11]);
    end

endmodule

// File: rtl/chr_xlate.sv
module chr_xlate #(
    parameter int BANK_W   = 8,
    parameter int OFFS_W   = 10,
    parameter int WIN_BITS = 3,
    localparam int WIN_CNT = 1 << WIN_BITS,
    localparam int CHR_W   = BANK_W + OFFS_W
) (
    input  logic [WIN_CNT*BANK_W-1:0]  bank_flat,
    input  logic [WIN_BITS-1:0]        win,
    input  logic [OFFS_W-1:0]          offs,
    output logic [CHR_W-1:0]           chr_addr
);

    logic [BANK_W-1:0] bank_sel;

    always_comb begin
        bank_sel = '0;
        for (int i = 0; i < WIN_CNT; i++) begin
            if (win == WIN_BITS'(i)) begin
                bank_sel = bank_flat[i*BANK_W +: BANK_W];
            end
        end
        chr_addr = {bank_sel, offs};
    end

endmodule

// File: rtl/chr_nt_mapper.sv
module chr_nt_mapper
    import chr_map_pkg::*;
#(
    parameter int BANK_W   = 8,
    parameter int OFFS_W   = 10,
    parameter int WIN_BITS = 3,
    localparam int WIN_CNT = 1 << WIN_BITS,
    localparam int VA_W    = OFFS_W + WIN_BITS + 1,
    localparam int CHR_W   = BANK_W + OFFS_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_we,
    input  logic [CMD_W-1:0]   cmd_sel,
    input  logic [BANK_W-1:0]  cmd_data,
    input  logic [VA_W-1:0]    vaddr,
    output logic [CHR_W-1:0]   chr_addr,
    output logic               nt_hit,
    output logic               ntab_sel
);

    logic [WIN_CNT*BANK_W-1:0] bank_flat;
    mir_mode_e                 mode_q;

    chr_bank_file #(.BANK_W(BANK_W), .WIN_CNT(WIN_CNT)) u_banks (
        .clk       (clk),
        .rst       (rst),
        .we        (cmd_we),
        .sel       (cmd_sel),
        .data      (cmd_data),
        .bank_flat (bank_flat)
    );

    nt_mirror_ctrl #(.VA_W(VA_W)) u_mirror (
        .clk       (clk),
        .rst       (rst),
        .we        (cmd_we),
        .sel       (cmd_sel),
        .mode_data (cmd_data[1:0]),
        .vaddr     (vaddr),
        .mode_q    (mode_q),
        .nt_hit    (nt_hit),
        .ntab_sel  (ntab_sel)
    );

    chr_xlate #(.BANK_W(BANK_W), .OFFS_W(OFFS_W), .WIN_BITS(WIN_BITS)) u_xlate (
        .bank_flat (bank_flat),
        .win       (vaddr[OFFS_W +: WIN_BITS]),
        .offs      (vaddr[OFFS_W-1:0]),
        .chr_addr  (chr_addr)
    );

endmodule

// File: rtl/chr_nt_mapper_chk.sv
module chr_nt_mapper_chk
    import chr_map_pkg::*;
#(
    parameter int BANK_W   = 8,
    parameter int OFFS_W   = 10,
    parameter int WIN_BITS = 3,
    localparam int WIN_CNT = 1 << WIN_BITS,
    localparam int VA_W    = OFFS_W + WIN_BITS + 1,
    localparam int CHR_W   = BANK_W + OFFS_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cmd_we,
    input  logic [CMD_W-1:0]           cmd_sel,
    input  logic [BANK_W-1:0]          cmd_data,
    input  logic [VA_W-1:0]            vaddr,
    input  logic [CHR_W-1:0]           chr_addr,
    input  logic                       nt_hit,
    input  logic                       ntab_sel,
    input  logic [WIN_CNT*BANK_W-1:0]  bank_flat,
    input  logic [1:0]                 mode_q
);

    logic [BANK_W-1:0] bk [WIN_CNT];
    always_comb begin
        for (int i = 0; i < WIN_CNT; i++) begin
            bk[i] = bank_flat[i*BANK_W +: BANK_W];
        end
    end

    logic bank_wr;
    assign bank_wr = cmd_we && (cmd_sel < CMD_W'(WIN_CNT));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (bank_flat == '0) && (mode_q == 2'd0));

    // R2
    bank_load_chk: assert property (@(posedge clk) disable iff (rst)
        bank_wr |=> bk[$past(cmd_sel[WIN_BITS-1:0])] == $past(cmd_data));

    // R4
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bank_wr |=> $stable(bank_flat));

    // R5
    mode_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && cmd_sel == CMD_MIRROR) |=> mode_q == $past(cmd_data[1:0]));

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(cmd_we && cmd_sel == CMD_MIRROR) |=> $stable(mode_q));

    // R3
    xlate_bank_chk: assert property (@(posedge clk) disable iff (rst)
        chr_addr[CHR_W-1:OFFS_W] == bk[vaddr[OFFS_W +: WIN_BITS]]);

    // R6
    vert_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'd0) |-> ntab_sel == vaddr[10]);

    // R7
    horz_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'd1) |-> ntab_sel == vaddr[11]);

    // R8
    one_screen_chk: assert property (@(posedge clk) disable iff (rst)
        mode_q[1] |-> ntab_sel == mode_q[0]);

    // R9
    nt_range_chk: assert property (@(posedge clk) disable iff (rst)
        nt_hit == (vaddr >= VA_W'(14'h2000) && vaddr <= VA_W'(14'h2FFF)));

endmodule

bind chr_nt_mapper chr_nt_mapper_chk #(
    .BANK_W(BANK_W), .OFFS_W(OFFS_W), .WIN_BITS(WIN_BITS)
) u_chk (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_sel(cmd_sel),
    .cmd_data(cmd_data), .vaddr(vaddr), .chr_addr(chr_addr),
    .nt_hit(nt_hit), .ntab_sel(ntab_sel), .bank_flat(bank_flat),
    .mode_q(mode_q)
);

// File: tb/chr_nt_mapper_test.sv
module chr_nt_mapper_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_we = 1'b0;
    logic [3:0]  cmd_sel = '0;
    logic [7:0]  cmd_data = '0;
    logic [13:0] vaddr = '0;
    logic [17:0] chr_addr;
    logic        nt_hit;
    logic        ntab_sel;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    chr_nt_mapper uut (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_sel(cmd_sel),
        .cmd_data(cmd_data), .vaddr(vaddr), .chr_addr(chr_addr),
        .nt_hit(nt_hit), .ntab_sel(ntab_sel)
    );

    // {vaddr, expected chr_addr} for bank values 3C FF 01 80 7E 00 A5 5A
    localparam logic [31:0] VEC [8] = '{
        {14'h0000, 18'h0F000},
        {14'h07FF, 18'h3FFFF},
        {14'h0800, 18'h00400},
        {14'h0C01, 18'h20001},
        {14'h1234, 18'h1FA34},
        {14'h17FF, 18'h003FF},
        {14'h1800, 18'h29400},
        {14'h1FFF, 18'h16BFF}
    };
    localparam logic [7:0] BANKS [8] = '{8'h3C, 8'hFF, 8'h01, 8'h80,
                                         8'h7E, 8'h00, 8'hA5, 8'h5A};

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [3:0] s, logic [7:0] d);
        @(negedge clk);
        cmd_we = 1'b1; cmd_sel = s; cmd_data = d;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic probe(logic [13:0] a);
        @(negedge clk);
        vaddr = a;
        #1;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state
        probe(14'h1C05); chk("R1 bank zero", 32'(chr_addr), 32'h00005);
        probe(14'h2400); chk("R1 mode vertical", 32'(ntab_sel), 1);
        chk("R9 nt range 2400", 32'(nt_hit), 1);

        // R2 / R3: program all windows, then walk the table
        for (int i = 0; i < 8; i++) wr(4'(i), BANKS[i]);
        for (int i = 0; i < 8; i++) begin
            probe(VEC[i][31:18]);
            chk("R3 window map", 32'(chr_addr), 32'(VEC[i][17:0]));
        end
        chk("R9 pattern not nt", 32'(nt_hit), 0);

        // R10: strobe low, no store
        @(negedge clk);
        cmd_sel = 4'h0; cmd_data = 8'hEE;
        repeat (2) @(negedge clk);
        probe(14'h0000); chk("R10 no write", 32'(chr_addr), 32'h0F000);
        cmd_sel = 4'hC; cmd_data = 8'h03;
        repeat (2) @(negedge clk);
        probe(14'h2400); chk("R10 mode kept", 32'(ntab_sel), 1);

        // R4: foreign codes ignored
        wr(4'h8, 8'hFF); wr(4'h9, 8'h12); wr(4'hB, 8'h34);
        wr(4'hD, 8'h81); wr(4'hE, 8'h02); wr(4'hF, 8'h03);
        probe(14'h1800); chk("R4 banks kept", 32'(chr_addr), 32'h29400);
        probe(14'h0000); chk("R4 bank0 kept", 32'(chr_addr), 32'h0F000);
        probe(14'h2400); chk("R4 mode kept a", 32'(ntab_sel), 1);
        probe(14'h2800); chk("R6 vertical a10=0", 32'(ntab_sel), 0);

        // R2: rewrite one window only
        wr(4'h3, 8'h00);
        probe(14'h0C01); chk("R2 rewrite win3", 32'(chr_addr), 32'h00001);
        probe(14'h1000); chk("R2 win4 unaffected", 32'(chr_addr), 32'h1F800);

        // R5 / R7: horizontal with upper bits set
        wr(4'hC, 8'hFD);
        probe(14'h2400); chk("R7 horz a11=0", 32'(ntab_sel), 0);
        probe(14'h2800); chk("R7 horz a11=1", 32'(ntab_sel), 1);
        probe(14'h2C00); chk("R5 upper ignored", 32'(ntab_sel), 1);

        // R8: single-screen modes
        wr(4'hC, 8'h02);
        probe(14'h2C00); chk("R8 one screen low", 32'(ntab_sel), 0);
        wr(4'hC, 8'h03);
        probe(14'h2000); chk("R8 one screen high", 32'(ntab_sel), 1);

        // R9: range edges
        probe(14'h1FFF); chk("R9 below", 32'(nt_hit), 0);
        probe(14'h2000); chk("R9 low edge", 32'(nt_hit), 1);
        probe(14'h2FFF); chk("R9 high edge", 32'(nt_hit), 1);
        probe(14'h3000); chk("R9 above", 32'(nt_hit), 0);

        // R1: reset after programming
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        probe(14'h1800); chk("R1 reset banks", 32'(chr_addr), 32'h00000);
        probe(14'h2400); chk("R1 reset mode", 32'(ntab_sel), 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule